// File: doc/BRIEF.md
# Three-Wire Configuration Register Front End

This block sits between an external microcontroller and the control logic of a low-power radio. The controller writes 16-bit words over three wires: an active-low load strobe, a serial clock and serial data. Each word carries a 2-bit target selector and a 14-bit payload. The payload lands in one of three configuration registers when the load strobe returns high.

Every wire is brought into the system clock domain through a synchronizer, and its edges are found there. Register A decides where the chip-enable and receive/transmit controls come from: either the external enable and direction pins, or bits held in A. Register A can also keep the internal clock running while the chip is disabled, and it can route the raw limiter signals onto the receive pins in place of the demodulated data. Registers B and C are exposed as raw fields. Only the transmit power index is decoded from register C.

Top module: `cfg3w_top`

## Requirements
- R1: The block shifts serial data in most significant bit first, on each rising serial clock edge, while the strobe `load_n_i` is low. A rising edge of `load_n_i` commits the word. The new register value is visible within 6 system clocks of that edge.
- R2: Word bits [15:14] pick the target: 00 selects register A, 01 register B, 10 register C. Bits [13:0] become the payload. Selector 11 leaves every register unchanged.
- R3: A word is discarded when `load_n_i` rises after any number of shifted bits other than exactly 16. No register changes.
- R4: When A[13]=0, the effective enable equals `en_pin_i` and the direction equals `dir_pin_i`. When A[13]=1, they equal A[11] and A[10], and the pin levels have no effect.
- R5: `clk_run_o` is 1 whenever A[12]=1. When A[12]=0 it equals the effective enable.
- R6: While the effective enable is 0, `rx_mode_o`, `tx_mode_o`, `bypass_o`, `rx_data_o`, `rx_clk_o` and `tx_pwr_o` are all 0. Serial writes are still accepted in this state.
- R7: A direction value of 1 selects receive and 0 selects transmit. When enabled, `rx_mode_o` is the direction and `tx_mode_o` is its inverse.
- R8: When enabled and A[9:6]=0100, `bypass_o` is 1, `rx_data_o` carries `lim_i_i` and `rx_clk_o` carries `lim_q_i`. Otherwise, when enabled, they carry `demod_data_i` and `rec_clk_i`.
- R9: When enabled, `tx_pwr_o` equals C[13:12], where 00 is the lowest power and 11 the highest.
- R10: Reset clears all three registers to zero. This gives pin control, a clock that follows the enable, and no bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_n_i | input | 1 | Serial load strobe, low while shifting |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data |
| en_pin_i | input | 1 | External chip enable pin |
| dir_pin_i | input | 1 | External direction pin, 1 = receive |
| demod_data_i | input | 1 | Demodulated receive data |
| rec_clk_i | input | 1 | Recovered receive clock |
| lim_i_i | input | 1 | Raw I limiter output |
| lim_q_i | input | 1 | Raw Q limiter output |
| chip_en_o | output | 1 | Effective chip enable |
| clk_run_o | output | 1 | Internal clock run request |
| rx_mode_o | output | 1 | Receive mode active |
| tx_mode_o | output | 1 | Transmit mode active |
| bypass_o | output | 1 | Demodulator bypass active |
| rx_data_o | output | 1 | Receive data output |
| rx_clk_o | output | 1 | Receive clock output |
| tx_pwr_o | output | 2 | Transmit power index |
| reg_a_o | output | 14 | Register A contents |
| reg_b_o | output | 14 | Register B contents |
| reg_c_o | output | 14 | Register C contents |

## Verification
The hardest case to reach is a strobe edge that arrives after a wrong bit count. From the ports it looks like any other write, except that nothing may change afterwards. The bench sends 15-bit and 17-bit frames whose payloads differ from the stored values, so that a wrongly accepted frame would show. A second hard case is a write made while the chip is disabled. To reach it, the bench first clears A[11] under register control, then writes register C and reads the new value back once the chip is enabled again.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned PAY_W  = WORD_W - SEL_W;
  localparam int unsigned NREG   = 3;
  localparam int unsigned CNT_W  = $clog2(WORD_W + 2);

  typedef logic [PAY_W-1:0]  payload_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_A    = 2'b00,
    SEL_B    = 2'b01,
    SEL_C    = 2'b10,
    SEL_NONE = 2'b11
  } sel_e;

  // register A field positions
  localparam int unsigned A_SRC_REG = 13;
  localparam int unsigned A_CLK_ON  = 12;
  localparam int unsigned A_ENABLE  = 11;
  localparam int unsigned A_DIR     = 10;
  localparam int unsigned A_BYP_HI  = 9;
  localparam int unsigned A_BYP_LO  = 6;
  localparam logic [3:0]  BYP_CODE  = 4'b0100;
  // register C field positions
  localparam int unsigned C_PWR_HI  = 13;
  localparam int unsigned C_PWR_LO  = 12;
endpackage

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
  parameter int unsigned    W       = 3,
  parameter int unsigned    STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else            stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cfg3w_shift.sv
module cfg3w_shift
  import cfg3w_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_n_s_i,
  input  logic  sck_s_i,
  input  logic  sdi_s_i,
  output logic  commit_o,
  output word_t word_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(WORD_W + 1);

  logic             load_n_q, sck_q;
  logic             load_rise, load_fall, sck_rise;
  word_t            shreg_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_n_q <= 1'b1;
      sck_q    <= 1'b0;
    end else begin
      load_n_q <= load_n_s_i;
      sck_q    <= sck_s_i;
    end
  end

  assign load_rise = load_n_s_i & ~load_n_q;
  assign load_fall = ~load_n_s_i & load_n_q;
  assign sck_rise  = sck_s_i & ~sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (load_rise || load_fall) begin
      cnt_q <= '0;
    end else if (sck_rise && !load_n_s_i) begin
      shreg_q <= {shreg_q[WORD_W-2:0], sdi_s_i};
      if (cnt_q != OVER) cnt_q <= cnt_q + 1'b1;
    end
  end

  // only an exact-length frame is committed
  assign commit_o = load_rise && (cnt_q == FULL);
  assign word_o   = shreg_q;

  AST_HOLD_WHILE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_n_s_i && load_n_q) |=> $stable(shreg_q)); // R1
  AST_CNT_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_rise |=> (cnt_q == '0)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == OVER) |=> (cnt_q == OVER) || (cnt_q == '0)); // R3
endmodule

// File: rtl/cfg3w_regs.sv
module cfg3w_regs
  import cfg3w_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     commit_i,
  input  word_t    word_i,
  output payload_t reg_o [NREG]
);
  sel_e     sel;
  payload_t pay;
  payload_t reg_q [NREG];

  assign sel = sel_e'(word_i[WORD_W-1 -: SEL_W]);
  assign pay = word_i[PAY_W-1:0];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   reg_q[r] <= '0;
      else if (commit_i && (sel == sel_e'(SEL_W'(r)))) reg_q[r] <= pay;
    end
    assign reg_o[r] = reg_q[r];

    AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !commit_i |=> $stable(reg_q[r])); // R1
    AST_UNUSED_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit_i && sel == SEL_NONE) |=> $stable(reg_q[r])); // R2
  end
endmodule

// File: rtl/cfg3w_ctrl.sv
module cfg3w_ctrl
  import cfg3w_pkg::*;
(
  input  payload_t reg_a_i,
  input  payload_t reg_c_i,
  input  logic     en_pin_i,
  input  logic     dir_pin_i,
  input  logic     demod_data_i,
  input  logic     rec_clk_i,
  input  logic     lim_i_i,
  input  logic     lim_q_i,
  output logic     chip_en_o,
  output logic     clk_run_o,
  output logic     rx_mode_o,
  output logic     tx_mode_o,
  output logic     bypass_o,
  output logic     rx_data_o,
  output logic     rx_clk_o,
  output logic [1:0] tx_pwr_o
);
  logic en_eff, dir_eff, byp_sel;

  always_comb begin
    en_eff    = reg_a_i[A_SRC_REG] ? reg_a_i[A_ENABLE] : en_pin_i;
    dir_eff   = reg_a_i[A_SRC_REG] ? reg_a_i[A_DIR]    : dir_pin_i;
    byp_sel   = (reg_a_i[A_BYP_HI:A_BYP_LO] == BYP_CODE);
    chip_en_o = en_eff;
    clk_run_o = reg_a_i[A_CLK_ON] | en_eff;
    rx_mode_o = en_eff & dir_eff;
    tx_mode_o = en_eff & ~dir_eff;
    bypass_o  = en_eff & byp_sel;
    rx_data_o = en_eff & (byp_sel ? lim_i_i : demod_data_i);
    rx_clk_o  = en_eff & (byp_sel ? lim_q_i : rec_clk_i);
    tx_pwr_o  = en_eff ? reg_c_i[C_PWR_HI:C_PWR_LO] : 2'b00;
  end
endmodule

// File: rtl/cfg3w_top.sv
module cfg3w_top
  import cfg3w_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_n_i,
  input  logic        sck_i,
  input  logic        sdi_i,
  input  logic        en_pin_i,
  input  logic        dir_pin_i,
  input  logic        demod_data_i,
  input  logic        rec_clk_i,
  input  logic        lim_i_i,
  input  logic        lim_q_i,
  output logic        chip_en_o,
  output logic        clk_run_o,
  output logic        rx_mode_o,
  output logic        tx_mode_o,
  output logic        bypass_o,
  output logic        rx_data_o,
  output logic        rx_clk_o,
  output logic [1:0]  tx_pwr_o,
  output logic [13:0] reg_a_o,
  output logic [13:0] reg_b_o,
  output logic [13:0] reg_c_o
);
  logic [2:0] sync_q;
  logic       commit;
  word_t      word;
  payload_t   regs [NREG];

  cfg3w_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({load_n_i, sck_i, sdi_i}),
    .q_o   (sync_q)
  );

  cfg3w_shift u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_n_s_i(sync_q[2]),
    .sck_s_i   (sync_q[1]),
    .sdi_s_i   (sync_q[0]),
    .commit_o  (commit),
    .word_o    (word)
  );

  cfg3w_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .commit_i(commit),
    .word_i  (word),
    .reg_o   (regs)
  );

  cfg3w_ctrl u_ctrl (
    .reg_a_i     (regs[0]),
    .reg_c_i     (regs[2]),
    .en_pin_i    (en_pin_i),
    .dir_pin_i   (dir_pin_i),
    .demod_data_i(demod_data_i),
    .rec_clk_i   (rec_clk_i),
    .lim_i_i     (lim_i_i),
    .lim_q_i     (lim_q_i),
    .chip_en_o   (chip_en_o),
    .clk_run_o   (clk_run_o),
    .rx_mode_o   (rx_mode_o),
    .tx_mode_o   (tx_mode_o),
    .bypass_o    (bypass_o),
    .rx_data_o   (rx_data_o),
    .rx_clk_o    (rx_clk_o),
    .tx_pwr_o    (tx_pwr_o)
  );

  assign reg_a_o = regs[0];
  assign reg_b_o = regs[1];
  assign reg_c_o = regs[2];

  AST_CLK_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_a_o[A_CLK_ON] |-> clk_run_o); // R5
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chip_en_o |-> !(rx_mode_o | tx_mode_o | bypass_o | rx_data_o | rx_clk_o | (|tx_pwr_o))); // R6
  AST_ONE_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_mode_o, tx_mode_o})); // R7
  AST_PIN_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_a_o[A_SRC_REG] && $stable(reg_a_o)) |-> $stable(chip_en_o)); // R4
endmodule

// File: tb/tb_cfg3w_top.sv
module tb_cfg3w_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic load_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic en_pin = 1'b0, dir_pin = 1'b0;
  logic demod = 1'b0, recclk = 1'b0, lim_i = 1'b0, lim_q = 1'b0;
  logic chip_en, clk_run, rx_mode, tx_mode, bypass, rx_data, rx_clk;
  logic [1:0]  tx_pwr;
  logic [13:0] reg_a, reg_b, reg_c;

  int total = 0, bad = 0;
  bit cmp_on = 1'b0;
  int cyc = 0;
  logic [13:0] m_regs [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg3w_top dut (
    .clk_i(clk), .rst_ni(rst_n), .load_n_i(load_n), .sck_i(sck), .sdi_i(sdi),
    .en_pin_i(en_pin), .dir_pin_i(dir_pin), .demod_data_i(demod), .rec_clk_i(recclk),
    .lim_i_i(lim_i), .lim_q_i(lim_q), .chip_en_o(chip_en), .clk_run_o(clk_run),
    .rx_mode_o(rx_mode), .tx_mode_o(tx_mode), .bypass_o(bypass), .rx_data_o(rx_data),
    .rx_clk_o(rx_clk), .tx_pwr_o(tx_pwr), .reg_a_o(reg_a), .reg_b_o(reg_b), .reg_c_o(reg_c)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural view of the outputs from model registers and pin levels
  task automatic cmp_all(string tag);
    logic en, dir, byp;
    en  = m_regs[0][13] ? m_regs[0][11] : en_pin;
    dir = m_regs[0][13] ? m_regs[0][10] : dir_pin;
    byp = (m_regs[0][9:6] == 4'b0100);
    chk({tag, " R2 reg_a"}, 32'(reg_a), 32'(m_regs[0]));
    chk({tag, " R2 reg_b"}, 32'(reg_b), 32'(m_regs[1]));
    chk({tag, " R2 reg_c"}, 32'(reg_c), 32'(m_regs[2]));
    chk({tag, " R4 chip_en"}, 32'(chip_en), 32'(en));
    chk({tag, " R5 clk_run"}, 32'(clk_run), 32'(m_regs[0][12] | en));
    chk({tag, " R7 rx_mode"}, 32'(rx_mode), 32'(en & dir));
    chk({tag, " R7 tx_mode"}, 32'(tx_mode), 32'(en & !dir));
    chk({tag, " R8 bypass"}, 32'(bypass), 32'(en & byp));
    chk({tag, " R8 rx_data"}, 32'(rx_data), 32'(en & (byp ? lim_i : demod)));
    chk({tag, " R8 rx_clk"}, 32'(rx_clk), 32'(en & (byp ? lim_q : recclk)));
    chk({tag, " R9 tx_pwr"}, 32'(tx_pwr), en ? 32'(m_regs[2][13:12]) : 32'd0);
  endtask

  // free-running data pattern on the receive-side inputs, compare each clock
  always @(negedge clk) begin
    cyc++;
    demod  <= cyc[0];
    recclk <= cyc[1];
    lim_i  <= cyc[2];
    lim_q  <= ~cyc[0];
  end
  always @(posedge clk) if (cmp_on) begin
    #1 cmp_all("clk");
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  // shifts out bits[n-1:0] MSB first; accept tells the model whether to commit
  task automatic send(logic [16:0] bits, int n, bit accept);
    cmp_on = 1'b0;
    load_n = 1'b0;
    wait_clk(HALF_SCK);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      wait_clk(HALF_SCK);
      sck = 1'b1;
      wait_clk(HALF_SCK);
      sck = 1'b0;
    end
    wait_clk(HALF_SCK);
    load_n = 1'b1;
    wait_clk(6);
    if (accept && bits[15:14] != 2'b11) m_regs[bits[15:14]] = bits[13:0];
    cmp_on = 1'b1;
  endtask

  task automatic wr(logic [1:0] sel, logic [13:0] pay);
    send({1'b0, sel, pay}, 16, 1'b1);
  endtask

  initial begin
    for (int r = 0; r < 3; r++) m_regs[r] = '0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    // R10 reset state
    chk("R10 reg_a", 32'(reg_a), 0);
    chk("R10 reg_b", 32'(reg_b), 0);
    chk("R10 reg_c", 32'(reg_c), 0);
    chk("R10 clk_run follows pin", 32'(clk_run), 0);
    chk("R10 no bypass", 32'(bypass), 0);
    cmp_on = 1'b1;

    // R4 pin control, R7 direction encoding
    en_pin = 1'b1; dir_pin = 1'b1; wait_clk(2);
    chk("R7 rx when dir=1", 32'(rx_mode), 1);
    dir_pin = 1'b0; wait_clk(2);
    chk("R7 tx when dir=0", 32'(tx_mode), 1);

    // R1 R2 each register target
    wr(2'b01, 14'h2a5c);
    chk("R1 reg_b loaded", 32'(reg_b), 32'h2a5c);
    wr(2'b10, 14'h3001);
    chk("R9 pwr index 11", 32'(tx_pwr), 3);
    wr(2'b10, 14'h1abc);
    chk("R9 pwr index 01", 32'(tx_pwr), 1);
    wr(2'b00, 14'h0155);
    chk("R1 reg_a loaded", 32'(reg_a), 32'h0155);

    // R2 unused selector
    send({3'b011, 14'h3fff}, 16, 1'b1);
    chk("R2 sel11 a", 32'(reg_a), 32'h0155);
    chk("R2 sel11 c", 32'(reg_c), 32'h1abc);

    // R3 short and long frames
    send({3'b001, 14'h0777}, 15, 1'b0);
    chk("R3 short frame b", 32'(reg_b), 32'h2a5c);
    send({3'b101, 14'h0777}, 17, 1'b0);
    chk("R3 long frame b", 32'(reg_b), 32'h2a5c);

    // R4 register control: enable=1, receive; pins ignored
    wr(2'b00, 14'h2c00);
    en_pin = 1'b0; dir_pin = 1'b0; wait_clk(3);
    chk("R4 pins ignored en", 32'(chip_en), 1);
    chk("R4 pins ignored rx", 32'(rx_mode), 1);

    // R8 bypass while enabled
    wr(2'b00, 14'h2d00);
    chk("R8 bypass on", 32'(bypass), 1);
    wait_clk(5);

    // R5 R6 disabled with clock forced; write still accepted
    wr(2'b00, 14'h3100);
    chk("R5 clk forced", 32'(clk_run), 1);
    chk("R6 off pwr", 32'(tx_pwr), 0);
    chk("R6 off bypass", 32'(bypass), 0);
    wr(2'b10, 14'h2000);
    chk("R6 write while off", 32'(reg_c), 32'h2000);
    wr(2'b00, 14'h2800);
    chk("R6 pwr after reenable", 32'(tx_pwr), 2);

    // R5 clock follows enable when not forced
    wr(2'b00, 14'h2000);
    chk("R5 clk off with enable", 32'(clk_run), 0);
    wait_clk(4);

    cmp_on = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule